// File: doc/BRIEF.md
# ATA Command Decode and Status Engine

This block sits behind the task-file Command register of a flash storage card's ATA host interface. When the host writes an opcode, the block captures the Feature, Sector Count, cylinder and head values. It decodes the opcode and goes busy. It then either finishes the command by itself or hands it to the media back end through a request/acknowledge pair. On completion it posts a Status byte, an Error byte and the Sector Count value.

Many legacy commands are kept only for compatibility. These are the idle and standby family, recalibrate, check power, seek, sleep and the geometry and configuration commands. They finish locally after a fixed single execution cycle. Some of them alter configuration state: the internal clock-speed code, the multiple-block enable, the translation geometry and the sleep flag. Seek range-checks its address against the current geometry. Read, write and verify are handed to the media side, and the engine waits there until that side reports done or error.

A parameter enables the older duplicate opcodes, so one integration can answer to both opcode sets.

Top module: `ata_cmd_engine`

## Requirements
- R1: After reset the Status output is 50h (DRDY bit 6 and DSC bit 4 set) and Error is 00h. Sectors-per-track is 32, the head count is 4, the clock code is 0, and multiple mode, sleep and the media request are all off.
- R2: A command is accepted only while BSY (Status bit 7) is clear. In the cycle after acceptance, Status reads exactly 80h. A locally completed command posts its result one cycle later, so BSY is high for exactly one cycle. Sector Count takes the value written with the accepted command.
- R3: A command write while BSY is set is ignored: it changes neither the media operation nor Sector Count nor the result of the running command.
- R4: Opcodes 10h, E0h, E1h, E2h, E3h and the duplicates 94h, 95h, 96h, 97h complete with Status 50h and Error 00h.
- R5: Check Power (E5h, duplicate 98h) completes with Status 50h, Error 00h and Sector Count 00h.
- R6: Set Features (EFh) with Feature 97h and a Sector Count below the number of clock codes (3) loads that code as the clock selection and completes good. Any other Feature value, or a code that is out of range, posts Status 51h with ABRT (Error bit 2) and leaves the clock code unchanged.
- R7: Set Multiple (C6h) with count 1 enables multiple mode and completes good. Any other count posts Status 51h and Error 04h, and leaves multiple mode disabled.
- R8: Seek (70h) posts Status 51h with IDNF (Error bit 4, Error 10h) when the head is not below the current head count or the cylinder is not below the cylinder count (1024). Otherwise it completes good.
- R9: Initialize Parameters (91h) sets sectors-per-track to the Sector Count value and the head count to the head value plus one. Later seeks are range-checked against the new head count.
- R10: Sleep (E6h, duplicate 99h) completes with Status 50h and sets the sleep output. The sleep output clears when the next command is accepted.
- R11: Read (20h), write (30h) and verify (40h) raise the media request, with operation code 0, 1 or 2 respectively. The request stays high with BSY until done or error arrives, and drops in the next cycle. On done, read and write post 58h (DRQ bit 3) and verify posts 50h. On error, Status is 51h with UNC (Error 40h).
- R12: An unrecognised opcode posts Status 51h and Error 04h, with DRDY still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Opcode written |
| feat_in | input | 8 | Feature register value |
| scnt_in | input | 8 | Sector Count register value |
| cyl_in | input | CYL_BITS | Cylinder value |
| head_in | input | HEAD_BITS | Head value |
| status_o | output | 8 | Status register |
| error_o | output | 8 | Error register |
| scnt_o | output | 8 | Sector Count as returned to the host |
| spt_o | output | 8 | Current sectors per track |
| heads_o | output | HEAD_BITS+1 | Current head count |
| clk_sel_o | output | CLKW | Selected internal clock code |
| mult_en_o | output | 1 | Multiple-block mode enabled |
| sleep_o | output | 1 | Low-power state flag |
| media_req_o | output | 1 | Request to the media back end |
| media_op_o | output | 2 | Media operation: 0 read, 1 write, 2 verify |
| media_done_i | input | 1 | Media back end finished without error |
| media_err_i | input | 1 | Media back end finished with error |

## Verification
BSY is due one clock edge after the accepting edge. A local result is due on the edge after that. A media result is due on the edge that samples done or error, and the request drops on that same edge. The driver applies stimulus on falling edges and reads the BSY pattern half a cycle after each due edge. It pushes each expected Status/Error/Sector Count triple into a queue. A monitor pops one triple at every falling edge where it sees BSY fall, and compares it there. Configuration outputs are read in the idle cycle after completion, and the sleep flag is also read in the busy cycle that follows the next acceptance.

// File: rtl/ata_cmd_pkg.sv
package ata_cmd_pkg;

   localparam int ST_BSY  = 7;
   localparam int ST_DRDY = 6;
   localparam int ST_DSC  = 4;
   localparam int ST_DRQ  = 3;
   localparam int ST_ERR  = 0;

   localparam int ER_UNC  = 6;
   localparam int ER_IDNF = 4;
   localparam int ER_ABRT = 2;

   localparam logic [7:0] ST_READY = 8'h50;
   localparam logic [7:0] ST_BUSY  = 8'h80;

   typedef enum logic [3:0] {
      CL_NOP, CL_CHKPWR, CL_SLEEP, CL_SETFEAT, CL_SETMULT,
      CL_SEEK, CL_INITP, CL_RD, CL_WR, CL_VFY, CL_BAD
   } cmd_class_t;

   typedef enum logic [1:0] {
      MOP_READ = 2'd0, MOP_WRITE = 2'd1, MOP_VERIFY = 2'd2
   } media_op_t;

   typedef enum logic [1:0] {
      FS_IDLE, FS_EXEC, FS_MEDIA
   } fsm_t;

   localparam logic [7:0] FEAT_CLOCK = 8'h97;

endpackage

// File: rtl/ata_cmd_decode.sv
module ata_cmd_decode
   import ata_cmd_pkg::*;
#(
   parameter bit LEGACY_OPS = 1'b1
) (
   input  logic [7:0] opcode,
   output cmd_class_t cls
);

   cmd_class_t main_cls;
   cmd_class_t old_cls;

   always_comb begin
      case (opcode)
         8'h10, 8'hE0, 8'hE1, 8'hE2, 8'hE3: main_cls = CL_NOP;
         8'hE5: main_cls = CL_CHKPWR;
         8'hE6: main_cls = CL_SLEEP;
         8'hEF: main_cls = CL_SETFEAT;
         8'hC6: main_cls = CL_SETMULT;
         8'h70: main_cls = CL_SEEK;
         8'h91: main_cls = CL_INITP;
         8'h20: main_cls = CL_RD;
         8'h30: main_cls = CL_WR;
         8'h40: main_cls = CL_VFY;
         default: main_cls = CL_BAD;
      endcase
   end

   generate
      if (LEGACY_OPS) begin : g_legacy
         always_comb begin
            case (opcode)
               8'h94, 8'h95, 8'h96, 8'h97: old_cls = CL_NOP;
               8'h98: old_cls = CL_CHKPWR;
               8'h99: old_cls = CL_SLEEP;
               default: old_cls = CL_BAD;
            endcase
         end
      end else begin : g_no_legacy
         assign old_cls = CL_BAD;
      end
   endgenerate

   assign cls = (main_cls != CL_BAD) ? main_cls : old_cls;

endmodule

// File: rtl/ata_cmd_eval.sv
module ata_cmd_eval
   import ata_cmd_pkg::*;
#(
   parameter int CYL_BITS  = 16,
   parameter int HEAD_BITS = 4,
   parameter int CYL_COUNT = 1024,
   parameter int CLK_CODES = 3
) (
   input  cmd_class_t           cls,
   input  logic [7:0]           feat,
   input  logic [7:0]           scnt,
   input  logic [CYL_BITS-1:0]  cyl,
   input  logic [HEAD_BITS-1:0] head,
   input  logic [HEAD_BITS:0]   heads_cur,
   output logic                 fail,
   output logic [7:0]           errbits
);

   localparam logic [CYL_BITS:0] CYL_LIM = (CYL_BITS+1)'(CYL_COUNT);
   localparam logic [7:0]        CLK_LIM = 8'(CLK_CODES);

   logic feat_ok;
   logic seek_ok;

   assign feat_ok = (feat == FEAT_CLOCK) && (scnt < CLK_LIM);
   assign seek_ok = ({1'b0, head} < heads_cur) && ({1'b0, cyl} < CYL_LIM);

   always_comb begin
      errbits = 8'h00;
      case (cls)
         CL_SETFEAT: if (!feat_ok)      errbits[ER_ABRT] = 1'b1;
         CL_SETMULT: if (scnt != 8'd1)  errbits[ER_ABRT] = 1'b1;
         CL_SEEK:    if (!seek_ok)      errbits[ER_IDNF] = 1'b1;
         CL_BAD:                        errbits[ER_ABRT] = 1'b1;
         default: ;
      endcase
   end

   assign fail = |errbits;

endmodule

// File: rtl/ata_cmd_cfg.sv
module ata_cmd_cfg
   import ata_cmd_pkg::*;
#(
   parameter int HEAD_BITS = 4,
   parameter int DEF_SPT   = 32,
   parameter int DEF_HEADS = 4,
   parameter int CLKW      = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 accept,
   input  logic                 exec,
   input  logic                 fail,
   input  cmd_class_t           cls,
   input  logic [7:0]           scnt_q,
   input  logic [HEAD_BITS-1:0] head_q,
   output logic [7:0]           spt_o,
   output logic [HEAD_BITS:0]   heads_o,
   output logic [CLKW-1:0]      clk_sel_o,
   output logic                 mult_en_o,
   output logic                 sleep_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spt_o     <= 8'(DEF_SPT);
         heads_o   <= (HEAD_BITS+1)'(DEF_HEADS);
         clk_sel_o <= '0;
         mult_en_o <= 1'b0;
         sleep_o   <= 1'b0;
      end else begin
         if (accept) sleep_o <= 1'b0;
         if (exec) begin
            case (cls)
               CL_SETFEAT: if (!fail) clk_sel_o <= scnt_q[CLKW-1:0];
               CL_SETMULT: mult_en_o <= !fail;
               CL_INITP: begin
                  spt_o   <= scnt_q;
                  heads_o <= {1'b0, head_q} + 1'b1;
               end
               CL_SLEEP: sleep_o <= 1'b1;
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ata_cmd_engine.sv
module ata_cmd_engine
   import ata_cmd_pkg::*;
#(
   parameter int CYL_BITS   = 16,
   parameter int HEAD_BITS  = 4,
   parameter int CYL_COUNT  = 1024,
   parameter int DEF_SPT    = 32,
   parameter int DEF_HEADS  = 4,
   parameter int CLK_CODES  = 3,
   parameter bit LEGACY_OPS = 1'b1,
   localparam int CLKW = (CLK_CODES > 1) ? $clog2(CLK_CODES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_we,
   input  logic [7:0]           cmd_byte,
   input  logic [7:0]           feat_in,
   input  logic [7:0]           scnt_in,
   input  logic [CYL_BITS-1:0]  cyl_in,
   input  logic [HEAD_BITS-1:0] head_in,
   output logic [7:0]           status_o,
   output logic [7:0]           error_o,
   output logic [7:0]           scnt_o,
   output logic [7:0]           spt_o,
   output logic [HEAD_BITS:0]   heads_o,
   output logic [CLKW-1:0]      clk_sel_o,
   output logic                 mult_en_o,
   output logic                 sleep_o,
   output logic                 media_req_o,
   output logic [1:0]           media_op_o,
   input  logic                 media_done_i,
   input  logic                 media_err_i
);

   generate
      if (CLK_CODES < 1) begin : g_bad_clk
         $error("CLK_CODES must be at least 1");
      end
      if (DEF_HEADS < 1 || DEF_HEADS > (1 << HEAD_BITS)) begin : g_bad_heads
         $error("DEF_HEADS out of range for HEAD_BITS");
      end
      if (CYL_COUNT < 1 || CYL_COUNT > (1 << CYL_BITS)) begin : g_bad_cyl
         $error("CYL_COUNT out of range for CYL_BITS");
      end
      if (DEF_SPT < 1 || DEF_SPT > 255) begin : g_bad_spt
         $error("DEF_SPT must fit in eight bits");
      end
   endgenerate

   fsm_t                 state;
   cmd_class_t           dec_cls;
   cmd_class_t           cls_q;
   logic [7:0]           feat_q;
   logic [7:0]           scnt_q;
   logic [CYL_BITS-1:0]  cyl_q;
   logic [HEAD_BITS-1:0] head_q;
   logic                 accept;
   logic                 exec;
   logic                 fail;
   logic [7:0]           errbits;
   logic                 dec_media;
   logic [1:0]           dec_op;

   assign accept = cmd_we && (state == FS_IDLE);
   assign exec   = (state == FS_EXEC);

   ata_cmd_decode #(.LEGACY_OPS(LEGACY_OPS)) u_dec (
      .opcode (cmd_byte),
      .cls    (dec_cls)
   );

   ata_cmd_eval #(
      .CYL_BITS  (CYL_BITS),
      .HEAD_BITS (HEAD_BITS),
      .CYL_COUNT (CYL_COUNT),
      .CLK_CODES (CLK_CODES)
   ) u_eval (
      .cls       (cls_q),
      .feat      (feat_q),
      .scnt      (scnt_q),
      .cyl       (cyl_q),
      .head      (head_q),
      .heads_cur (heads_o),
      .fail      (fail),
      .errbits   (errbits)
   );

   ata_cmd_cfg #(
      .HEAD_BITS (HEAD_BITS),
      .DEF_SPT   (DEF_SPT),
      .DEF_HEADS (DEF_HEADS),
      .CLKW      (CLKW)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .exec      (exec),
      .fail      (fail),
      .cls       (cls_q),
      .scnt_q    (scnt_q),
      .head_q    (head_q),
      .spt_o     (spt_o),
      .heads_o   (heads_o),
      .clk_sel_o (clk_sel_o),
      .mult_en_o (mult_en_o),
      .sleep_o   (sleep_o)
   );

   always_comb begin
      dec_media = 1'b1;
      dec_op    = MOP_READ;
      case (dec_cls)
         CL_RD:  dec_op = MOP_READ;
         CL_WR:  dec_op = MOP_WRITE;
         CL_VFY: dec_op = MOP_VERIFY;
         default: dec_media = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= FS_IDLE;
         cls_q       <= CL_NOP;
         feat_q      <= '0;
         scnt_q      <= '0;
         cyl_q       <= '0;
         head_q      <= '0;
         status_o    <= ST_READY;
         error_o     <= 8'h00;
         scnt_o      <= 8'h00;
         media_req_o <= 1'b0;
         media_op_o  <= MOP_READ;
      end else begin
         case (state)
            FS_IDLE: begin
               if (cmd_we) begin
                  cls_q    <= dec_cls;
                  feat_q   <= feat_in;
                  scnt_q   <= scnt_in;
                  cyl_q    <= cyl_in;
                  head_q   <= head_in;
                  status_o <= ST_BUSY;
                  error_o  <= 8'h00;
                  scnt_o   <= scnt_in;
                  if (dec_media) begin
                     state       <= FS_MEDIA;
                     media_req_o <= 1'b1;
                     media_op_o  <= dec_op;
                  end else begin
                     state <= FS_EXEC;
                  end
               end
            end
            FS_EXEC: begin
               status_o         <= ST_READY;
               status_o[ST_ERR] <= fail;
               error_o          <= errbits;
               if (cls_q == CL_CHKPWR) scnt_o <= 8'h00;
               state <= FS_IDLE;
            end
            FS_MEDIA: begin
               if (media_err_i) begin
                  status_o         <= ST_READY;
                  status_o[ST_ERR] <= 1'b1;
                  error_o[ER_UNC]  <= 1'b1;
                  media_req_o      <= 1'b0;
                  state            <= FS_IDLE;
               end else if (media_done_i) begin
                  status_o         <= ST_READY;
                  status_o[ST_DRQ] <= (cls_q != CL_VFY);
                  media_req_o      <= 1'b0;
                  state            <= FS_IDLE;
               end
            end
            default: state <= FS_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ata_cmd_engine_chk.sv
module ata_cmd_engine_chk #(
   parameter int CLKW      = 2,
   parameter int CLK_CODES = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cmd_we,
   input logic [7:0]      status_o,
   input logic            media_req_o,
   input logic [1:0]      media_op_o,
   input logic            media_done_i,
   input logic            media_err_i,
   input logic            sleep_o,
   input logic [CLKW-1:0] clk_sel_o
);

   // R2
   bsy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !status_o[7]) |=> (status_o == 8'h80));

   // R2
   busy_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] |-> (status_o == 8'h80));

   // R2
   local_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[7] && !media_req_o) |=> !status_o[7]);

   // R3
   busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (media_req_o && cmd_we) |=> $stable(media_op_o));

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (media_req_o && !media_done_i && !media_err_i) |=> (media_req_o && status_o[7]));

   // R11
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (media_req_o && (media_done_i || media_err_i)) |=> (!media_req_o && !status_o[7]));

   // R12
   drdy_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_o[7] |-> status_o[6]);

   // R6
   clk_code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(clk_sel_o) < CLK_CODES);

   // R10
   sleep_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_o |-> !status_o[7]);

endmodule

bind ata_cmd_engine ata_cmd_engine_chk #(
   .CLKW      (CLKW),
   .CLK_CODES (CLK_CODES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_we       (cmd_we),
   .status_o     (status_o),
   .media_req_o  (media_req_o),
   .media_op_o   (media_op_o),
   .media_done_i (media_done_i),
   .media_err_i  (media_err_i),
   .sleep_o      (sleep_o),
   .clk_sel_o    (clk_sel_o)
);

// File: tb/ata_cmd_engine_test.sv
`timescale 1ns/1ps
module ata_cmd_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [7:0]  cmd_byte = 8'h00;
   logic [7:0]  feat_in = 8'h00;
   logic [7:0]  scnt_in = 8'h00;
   logic [15:0] cyl_in = 16'h0;
   logic [3:0]  head_in = 4'h0;
   logic [7:0]  status_o, error_o, scnt_o, spt_o;
   logic [4:0]  heads_o;
   logic [1:0]  clk_sel_o, media_op_o;
   logic        mult_en_o, sleep_o, media_req_o;
   logic        media_done_i = 1'b0;
   logic        media_err_i = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [23:0] q_val[$];
   string       q_tag[$];

   always #2.5 clk = ~clk;

   ata_cmd_engine uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
      .feat_in(feat_in), .scnt_in(scnt_in), .cyl_in(cyl_in), .head_in(head_in),
      .status_o(status_o), .error_o(error_o), .scnt_o(scnt_o), .spt_o(spt_o),
      .heads_o(heads_o), .clk_sel_o(clk_sel_o), .mult_en_o(mult_en_o),
      .sleep_o(sleep_o), .media_req_o(media_req_o), .media_op_o(media_op_o),
      .media_done_i(media_done_i), .media_err_i(media_err_i)
   );

   task automatic cmp(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // monitor: one expected result per falling BSY
   bit was_busy = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (was_busy && !status_o[7]) begin
            if (q_val.size() == 0) begin
               cmp("R2", "unexpected completion", 16'h1, 16'h0);
            end else begin
               logic [23:0] e;
               string t;
               e = q_val.pop_front();
               t = q_tag.pop_front();
               cmp(t, "status", {8'h0, status_o}, {8'h0, e[23:16]});
               cmp(t, "error",  {8'h0, error_o},  {8'h0, e[15:8]});
               cmp(t, "scnt",   {8'h0, scnt_o},   {8'h0, e[7:0]});
            end
         end
         was_busy = status_o[7];
      end
   end

   task automatic issue(input logic [7:0] op, input logic [7:0] ft,
                        input logic [7:0] sc, input logic [15:0] cy,
                        input logic [3:0] hd, input logic [7:0] est,
                        input logic [7:0] eer, input logic [7:0] esc,
                        input string tag);
      q_val.push_back({est, eer, esc});
      q_tag.push_back(tag);
      @(negedge clk);
      cmd_byte = op; feat_in = ft; scnt_in = sc; cyl_in = cy; head_in = hd;
      cmd_we = 1'b1;
      @(negedge clk);
      cmd_we = 1'b0;
      // R2: BSY only, one edge after acceptance
      cmp("R2", "busy status", {8'h0, status_o}, 16'h0080);
   endtask

   task automatic local_cmd(input logic [7:0] op, input logic [7:0] ft,
                            input logic [7:0] sc, input logic [15:0] cy,
                            input logic [3:0] hd, input logic [7:0] est,
                            input logic [7:0] eer, input logic [7:0] esc,
                            input string tag);
      issue(op, ft, sc, cy, hd, est, eer, esc, tag);
      @(negedge clk);
      // R2: local result on the second edge
      cmp("R2", "bsy cleared", {15'h0, status_o[7]}, 16'h0);
   endtask

   task automatic media_cmd(input logic [7:0] op, input logic [7:0] sc,
                            input logic [1:0] eop, input bit use_err,
                            input bit intrude, input logic [7:0] est,
                            input logic [7:0] eer);
      issue(op, 8'h00, sc, 16'h0, 4'h0, est, eer, sc, "R11");
      cmp("R11", "request raised", {15'h0, media_req_o}, 16'h1);
      cmp("R11", "media op", {14'h0, media_op_o}, {14'h0, eop});
      if (intrude) begin
         cmd_byte = 8'hE5; scnt_in = 8'h33; cmd_we = 1'b1;
         @(negedge clk);
         cmd_we = 1'b0;
      end
      repeat (3) @(negedge clk);
      cmp("R11", "request held", {15'h0, media_req_o}, 16'h1);
      if (intrude) begin
         // R3: ignored write left op and Sector Count alone
         cmp("R3", "op after busy write", {14'h0, media_op_o}, {14'h0, eop});
         cmp("R3", "scnt after busy write", {8'h0, scnt_o}, {8'h0, sc});
      end
      if (use_err) media_err_i = 1'b1; else media_done_i = 1'b1;
      @(negedge clk);
      media_err_i = 1'b0; media_done_i = 1'b0;
      cmp("R11", "request dropped", {15'h0, media_req_o}, 16'h0);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      cmp("R1", "status", {8'h0, status_o}, 16'h0050);
      cmp("R1", "error", {8'h0, error_o}, 16'h0000);
      cmp("R1", "spt", {8'h0, spt_o}, 16'd32);
      cmp("R1", "heads", {11'h0, heads_o}, 16'd4);
      cmp("R1", "clk_sel", {14'h0, clk_sel_o}, 16'h0);
      cmp("R1", "flags", {13'h0, mult_en_o, sleep_o, media_req_o}, 16'h0);

      // R4 no-op family
      local_cmd(8'hE3, 8'h00, 8'h05, 16'h0, 4'h0, 8'h50, 8'h00, 8'h05, "R4");
      local_cmd(8'h10, 8'h00, 8'h06, 16'h0, 4'h0, 8'h50, 8'h00, 8'h06, "R4");
      local_cmd(8'h97, 8'h00, 8'h07, 16'h0, 4'h0, 8'h50, 8'h00, 8'h07, "R4");
      local_cmd(8'hE0, 8'h00, 8'h08, 16'h0, 4'h0, 8'h50, 8'h00, 8'h08, "R4");

      // R5 check power
      local_cmd(8'hE5, 8'h00, 8'h07, 16'h0, 4'h0, 8'h50, 8'h00, 8'h00, "R5");
      local_cmd(8'h98, 8'h00, 8'hFF, 16'h0, 4'h0, 8'h50, 8'h00, 8'h00, "R5");

      // R6 set features
      local_cmd(8'hEF, 8'h97, 8'h02, 16'h0, 4'h0, 8'h50, 8'h00, 8'h02, "R6");
      @(negedge clk);
      cmp("R6", "clk code set", {14'h0, clk_sel_o}, 16'd2);
      local_cmd(8'hEF, 8'h97, 8'h03, 16'h0, 4'h0, 8'h51, 8'h04, 8'h03, "R6");
      local_cmd(8'hEF, 8'h55, 8'h01, 16'h0, 4'h0, 8'h51, 8'h04, 8'h01, "R6");
      @(negedge clk);
      cmp("R6", "clk code kept", {14'h0, clk_sel_o}, 16'd2);

      // R7 set multiple
      local_cmd(8'hC6, 8'h00, 8'h01, 16'h0, 4'h0, 8'h50, 8'h00, 8'h01, "R7");
      @(negedge clk);
      cmp("R7", "mult enabled", {15'h0, mult_en_o}, 16'h1);
      local_cmd(8'hC6, 8'h00, 8'h04, 16'h0, 4'h0, 8'h51, 8'h04, 8'h04, "R7");
      @(negedge clk);
      cmp("R7", "mult disabled", {15'h0, mult_en_o}, 16'h0);

      // R8 seek range checks against default geometry
      local_cmd(8'h70, 8'h00, 8'h00, 16'd100,  4'd3, 8'h50, 8'h00, 8'h00, "R8");
      local_cmd(8'h70, 8'h00, 8'h00, 16'd100,  4'd4, 8'h51, 8'h10, 8'h00, "R8");
      local_cmd(8'h70, 8'h00, 8'h00, 16'd1024, 4'd0, 8'h51, 8'h10, 8'h00, "R8");
      local_cmd(8'h70, 8'h00, 8'h00, 16'd1023, 4'd0, 8'h50, 8'h00, 8'h00, "R8");

      // R9 geometry change
      local_cmd(8'h91, 8'h00, 8'd17, 16'h0, 4'd7, 8'h50, 8'h00, 8'd17, "R9");
      @(negedge clk);
      cmp("R9", "spt", {8'h0, spt_o}, 16'd17);
      cmp("R9", "heads", {11'h0, heads_o}, 16'd8);
      local_cmd(8'h70, 8'h00, 8'h00, 16'd5, 4'd7, 8'h50, 8'h00, 8'h00, "R9");
      local_cmd(8'h70, 8'h00, 8'h00, 16'd5, 4'd8, 8'h51, 8'h10, 8'h00, "R9");

      // R10 sleep
      local_cmd(8'hE6, 8'h00, 8'h00, 16'h0, 4'h0, 8'h50, 8'h00, 8'h00, "R10");
      @(negedge clk);
      cmp("R10", "sleep set", {15'h0, sleep_o}, 16'h1);
      issue(8'hE3, 8'h00, 8'h00, 16'h0, 4'h0, 8'h50, 8'h00, 8'h00, "R10");
      cmp("R10", "sleep cleared", {15'h0, sleep_o}, 16'h0);
      @(negedge clk);
      local_cmd(8'h99, 8'h00, 8'h00, 16'h0, 4'h0, 8'h50, 8'h00, 8'h00, "R10");
      @(negedge clk);
      cmp("R10", "legacy sleep set", {15'h0, sleep_o}, 16'h1);

      // R11 media commands, R3 busy write
      media_cmd(8'h20, 8'h04, 2'd0, 1'b0, 1'b1, 8'h58, 8'h00);
      media_cmd(8'h40, 8'h02, 2'd2, 1'b0, 1'b0, 8'h50, 8'h00);
      media_cmd(8'h30, 8'h09, 2'd1, 1'b1, 1'b0, 8'h51, 8'h40);

      // R12 unknown opcode
      local_cmd(8'hAB, 8'h00, 8'h03, 16'h0, 4'h0, 8'h51, 8'h04, 8'h03, "R12");

      repeat (2) @(negedge clk);
      cmp("R2", "results left pending", 16'(q_val.size()), 16'h0);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule